// File: doc/BRIEF.md
# Byte-to-GCR Recoding Register

This peripheral takes the bit shuffling of 4-to-5 group coded recording (GCR) off the host processor. It sits on a byte-wide register bus. The core is a 40-bit window that shifts in one byte on every host write, so the window always holds the most recent five bytes written. Combinational lookup logic translates the window in both directions at the same time, and the host reads whichever form it needs at fixed offsets.

To encode, the host writes four plain bytes and reads five GCR bytes. The encoding covers the 32 most recently written bits. To decode, the host writes five GCR bytes and reads four plain bytes. The decoding covers all eight 5-bit groups of the window.

A group that is not a legal code word decodes to a zero nibble. If the host reads a plain byte built from such a group, a sticky error flag is set. Reading the status register clears that flag. The host never issues a command and never waits for completion: every read returns the conversion of the window as it stands.

Top module: `gcr_recoder`

## Requirements
- R1: After reset the window is all zeros, `bus_rdata` is 0x00 and the sticky error flag is clear. Reading the GCR bytes of the zero window returns 0x52, 0x94, 0xA5, 0x29, 0x4A.
- R2: Every write shifts the window left by eight bits, whatever the address. `bus_wdata` enters bits [7:0] and the oldest byte is discarded.
- R3: Offsets 4 to 8 return the GCR code of window bits [31:0], most significant byte first. Nibble 0-F maps to 01010, 01011, 10010, 10011, 01110, 01111, 10110, 10111, 01001, 11001, 11010, 11011, 01101, 11101, 11110, 10101. Nibble [31:28] becomes code bits [39:35].
- R4: Offsets 0 to 3 return the plain bytes decoded from the eight 5-bit groups of the whole window, most significant byte first. Group [39:35] becomes nibble [31:28].
- R5: A group that is not one of the sixteen code words decodes to nibble 0.
- R6: A read at offsets 0 to 3 whose byte uses an illegal group sets the sticky error flag, status bit 0.
- R7: A read at offset 9 (status) returns the flag as it was before the read, then clears it. Status bit 1 is a live flag that is 1 while any group of the window is illegal. Status bits 7:2 read as 0.
- R8: Read data appears on `bus_rdata` one clock after the read strobe and holds until the next read. Offsets 10 to 15 read 0x00.
- R9: Reads never change the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register offset for reads |
| bus_wr | input | 1 | Write strobe: shifts `bus_wdata` into the window |
| bus_wdata | input | 8 | Write data byte |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |

## Verification
The checker confirms on every cycle that each write shifts the window by exactly one byte and that the window is stable when there is no write. It also confirms that the sticky flag is set by a read of an illegal byte, is held until a status read and is cleared by that read, and that the read data holds between strobes. Only the bench scenarios can show that the code tables are correct. They do this by encoding a set of words, decoding the results back and checking that each word comes back unchanged. The bench also covers the ordering of bytes across offsets and the exact values in a status word.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

  // nibble -> 5-bit code word
  function automatic logic [4:0] gcr_enc(input logic [3:0] n);
    logic [4:0] c;
    case (n)
      4'h0: c = 5'b01010; 4'h1: c = 5'b01011; 4'h2: c = 5'b10010; 4'h3: c = 5'b10011;
      4'h4: c = 5'b01110; 4'h5: c = 5'b01111; 4'h6: c = 5'b10110; 4'h7: c = 5'b10111;
      4'h8: c = 5'b01001; 4'h9: c = 5'b11001; 4'hA: c = 5'b11010; 4'hB: c = 5'b11011;
      4'hC: c = 5'b01101; 4'hD: c = 5'b11101; 4'hE: c = 5'b11110; default: c = 5'b10101;
    endcase
    return c;
  endfunction

  typedef struct packed {
    logic       bad;
    logic [3:0] nib;
  } gcr_dec_t;

  // 5-bit group -> nibble, bad set for non-code words
  function automatic gcr_dec_t gcr_dec(input logic [4:0] g);
    gcr_dec_t r;
    r.bad = 1'b0;
    case (g)
      5'b01010: r.nib = 4'h0; 5'b01011: r.nib = 4'h1; 5'b10010: r.nib = 4'h2;
      5'b10011: r.nib = 4'h3; 5'b01110: r.nib = 4'h4; 5'b01111: r.nib = 4'h5;
      5'b10110: r.nib = 4'h6; 5'b10111: r.nib = 4'h7; 5'b01001: r.nib = 4'h8;
      5'b11001: r.nib = 4'h9; 5'b11010: r.nib = 4'hA; 5'b11011: r.nib = 4'hB;
      5'b01101: r.nib = 4'hC; 5'b11101: r.nib = 4'hD; 5'b11110: r.nib = 4'hE;
      5'b10101: r.nib = 4'hF;
      default: begin r.nib = 4'h0; r.bad = 1'b1; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gcr_shift_window.sv
module gcr_shift_window #(
  parameter int WIN_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [7:0]       din,
  output logic [WIN_W-1:0] win
);
  logic [WIN_W-1:0] win_d;

  always_comb begin
    win_d = win;
    if (shift_en) win_d = {win[WIN_W-9:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win <= '0;
    else        win <= win_d;
  end
endmodule

// File: rtl/gcr_encoder.sv
module gcr_encoder #(
  parameter int NGRP = 8
) (
  input  logic [NGRP*4-1:0] bin,
  output logic [NGRP*5-1:0] code
);
  import gcr_pkg::*;
  for (genvar i = 0; i < NGRP; i++) begin : g_nib
    assign code[i*5 +: 5] = gcr_enc(bin[i*4 +: 4]);
  end
endmodule

// File: rtl/gcr_decoder.sv
module gcr_decoder #(
  parameter int NGRP = 8
) (
  input  logic [NGRP*5-1:0] code,
  output logic [NGRP*4-1:0] bin,
  output logic [NGRP-1:0]   bad
);
  import gcr_pkg::*;
  for (genvar i = 0; i < NGRP; i++) begin : g_grp
    gcr_dec_t r;
    assign r          = gcr_dec(code[i*5 +: 5]);
    assign bin[i*4 +: 4] = r.nib;
    assign bad[i]     = r.bad;
  end
endmodule

// File: rtl/gcr_recoder.sv
module gcr_recoder #(
  parameter int BIN_BYTES = 4,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata
);
  localparam int NGRP      = BIN_BYTES * 2;
  localparam int WIN_W     = NGRP * 5;
  localparam int BIN_W     = BIN_BYTES * 8;
  localparam int GCR_BYTES = WIN_W / 8;
  localparam int GCR_BASE  = BIN_BYTES;
  localparam int STAT_ADDR = BIN_BYTES + GCR_BYTES;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] enc_code;
  logic [BIN_W-1:0] dec_bin;
  logic [NGRP-1:0]  grp_bad;

  gcr_shift_window #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_q), .shift_en(bus_wr), .din(bus_wdata), .win(win_q)
  );

  gcr_encoder #(.NGRP(NGRP)) u_enc (
    .bin(win_q[BIN_W-1:0]), .code(enc_code)
  );

  gcr_decoder #(.NGRP(NGRP)) u_dec (
    .code(win_q), .bin(dec_bin), .bad(grp_bad)
  );

  // read decode
  int unsigned a;
  logic [7:0]  rd_mux;
  logic        rd_bin_bad;
  logic        rd_stat;
  logic        err_q, err_d;
  logic [7:0]  rdata_d;

  always_comb begin
    a          = int'(bus_addr);
    rd_mux     = 8'h00;
    rd_bin_bad = 1'b0;
    rd_stat    = 1'b0;
    if (a < GCR_BASE) begin
      rd_mux     = dec_bin[(BIN_BYTES-1-a)*8 +: 8];
      rd_bin_bad = |grp_bad[(BIN_BYTES-1-a)*2 +: 2];
    end else if (a < STAT_ADDR) begin
      rd_mux = enc_code[(GCR_BYTES-1-(a-GCR_BASE))*8 +: 8];
    end else if (a == STAT_ADDR) begin
      rd_mux  = {6'b0, |grp_bad, err_q};
      rd_stat = 1'b1;
    end
  end

  always_comb begin
    err_d   = err_q;
    rdata_d = bus_rdata;
    if (bus_rd) begin
      rdata_d = rd_mux;
      if (rd_stat)    err_d = 1'b0;
      if (rd_bin_bad) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      err_q     <= 1'b0;
      bus_rdata <= 8'h00;
    end else begin
      err_q     <= err_d;
      bus_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/gcr_recoder_chk.sv
module gcr_recoder_chk #(
  parameter int BIN_BYTES = 4,
  parameter int ADDR_W    = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   bus_wr,
  input logic [7:0]             bus_wdata,
  input logic                   bus_rd,
  input logic [7:0]             bus_rdata,
  input logic [BIN_BYTES*10-1:0] win,
  input logic                   err,
  input logic [BIN_BYTES*2-1:0] bad
);
  localparam int WIN_W     = BIN_BYTES * 10;
  localparam int STAT_ADDR = BIN_BYTES + WIN_W / 8;

  logic stat_rd;
  logic bin_bad_rd;
  assign stat_rd = bus_rd && (int'(bus_addr) == STAT_ADDR);
  assign bin_bad_rd = bus_rd && (int'(bus_addr) < BIN_BYTES) &&
                      (|bad[(BIN_BYTES-1-int'(bus_addr)%BIN_BYTES)*2 +: 2]);

  // R2: one byte enters at the bottom per write
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> win == {$past(win[WIN_W-9:0]), $past(bus_wdata)});

  // R9: window unchanged without a write
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(win));

  // R6: reading an illegal plain byte raises the flag
  p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bin_bad_rd |=> err);

  // R7: status read clears the flag
  p_err_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !err);

  // R6: flag is sticky until a status read
  p_err_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !stat_rd) |=> err);

  // R8: read data holds between strobes
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind gcr_recoder gcr_recoder_chk #(.BIN_BYTES(BIN_BYTES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_q), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .win(win_q), .err(err_q), .bad(grp_bad)
);

// File: tb/gcr_recoder_test.sv
module gcr_recoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  gcr_recoder uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  localparam logic [31:0] VEC [6] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h0123_4567,
    32'h89AB_CDEF, 32'hA55A_3CC3, 32'hDEAD_BEEF
  };

  function automatic logic [4:0] m_enc(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b01010, 5'b01011, 5'b10010, 5'b10011,
                           5'b01110, 5'b01111, 5'b10110, 5'b10111,
                           5'b01001, 5'b11001, 5'b11010, 5'b11011,
                           5'b01101, 5'b11101, 5'b11110, 5'b10101};
    return t[n];
  endfunction

  function automatic logic [39:0] m_enc32(input logic [31:0] w);
    logic [39:0] c;
    for (int i = 0; i < 8; i++) c[i*5 +: 5] = m_enc(w[i*4 +: 4]);
    return c;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic [3:0] a = 4'd0);
    @(negedge clk); bus_wr = 1'b1; bus_wdata = d; bus_addr = a;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0]  d, d2;
    logic [39:0] code;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 rdata", bus_rdata, 8'h00);
    rd(4'd4, d); check("R1 gcr0", d, 8'h52);
    rd(4'd5, d); check("R1 gcr1", d, 8'h94);
    rd(4'd6, d); check("R1 gcr2", d, 8'hA5);
    rd(4'd7, d); check("R1 gcr3", d, 8'h29);
    rd(4'd8, d); check("R1 gcr4", d, 8'h4A);
    rd(4'd9, d); check("R1 status", d, 8'h02);

    // R3 / R4: table-driven round trips
    foreach (VEC[k]) begin
      for (int b = 3; b >= 0; b--) wr(VEC[k][b*8 +: 8]);
      code = m_enc32(VEC[k]);
      for (int j = 0; j < 5; j++) begin
        rd(4'(4 + j), d);
        check("R3 encode", d, code[(4-j)*8 +: 8]);
      end
      for (int j = 0; j < 5; j++) wr(code[(4-j)*8 +: 8]);
      for (int j = 0; j < 4; j++) begin
        rd(4'(j), d);
        check("R4 decode", d, VEC[k][(3-j)*8 +: 8]);
      end
      rd(4'd9, d); check("R7 status clean", d, 8'h00);
    end

    // R2: oldest byte falls off; write address ignored
    wr(8'h11, 4'd9); wr(8'h22, 4'd3); wr(8'h33, 4'd15); wr(8'h44, 4'd0);
    rd(4'd4, d); check("R2 shift", d, m_enc32(32'h11223344)[39:32]);
    rd(4'd8, d); check("R2 shift", d, m_enc32(32'h11223344)[7:0]);

    // R9: reads leave window unchanged
    rd(4'd8, d2); check("R9 reread", d2, d);

    // R8: hold and unused offsets
    repeat (4) @(negedge clk);
    check("R8 hold", bus_rdata, d);
    rd(4'd12, d); check("R8 unused", d, 8'h00);
    rd(4'd15, d); check("R8 unused", d, 8'h00);

    // R5 / R6 / R7: illegal group in the top position
    wr(8'h02); wr(8'hD6); wr(8'hB5); wr(8'hAD); wr(8'h6B);
    rd(4'd9, d); check("R7 live flag", d, 8'h02);
    rd(4'd1, d); check("R4 good byte", d, 8'h11);
    rd(4'd9, d); check("R6 no set on good", d, 8'h02);
    rd(4'd0, d); check("R5 bad nibble zero", d, 8'h01);
    rd(4'd9, d); check("R6 sticky set", d, 8'h03);
    rd(4'd9, d); check("R7 cleared", d, 8'h02);
    rd(4'd0, d);
    wr(8'h4A); wr(8'h52); wr(8'h94); wr(8'hA5); wr(8'h29);
    wr(8'h4A);
    rd(4'd9, d); check("R6 survives writes", d, 8'h01);
    rd(4'd9, d); check("R7 cleared again", d, 8'h00);

    // R1: asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); check("R1 rdata reset", bus_rdata, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(4'd7, d); check("R1 window reset", d, 8'h29);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule